// File: doc/BRIEF.md
# Cascaded DMA Channel Address Generator

This block keeps the address state of a seven-channel DMA subsystem built from two cascaded four-channel controllers, and turns each accepted transfer strobe into a full 32-bit system address. Channels 0 to 3 move bytes. Channels 5 to 7 move 16-bit words. Channel 4 is the cascade link and never transfers. Each channel owns a 16-bit current address, a 16-bit current count, base copies of both, two page bytes, and a mode byte that sets auto-reload and the stepping direction.

Software programs the channels through a byte-wide write port. A write selects a channel and a register. The 16-bit base registers are filled in two writes, low byte first. One pointer, shared by all channels, tracks which byte comes next. The arbiter outside the block issues a strobe with a channel number. One cycle later the block presents the address, the byte lanes and a terminal-count flag. It then steps the address and count of that channel.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `xfer_valid` and `xfer_tc` are 0, every usable channel is unblocked, all channel registers are 0, and the shared byte pointer selects the low byte.
- R2: A byte channel (0 to 3) outputs the address {page_hi[7:0], page_lo[7:0], current_address[15:0]}. `xfer_be` is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R3: A word channel (5 to 7) outputs {page_hi[7:0], page_lo[7:1], current_address[15:0], 1'b0}, so page_lo bit 0 is dropped. `xfer_be` is 2'b11.
- R4: Mode register (select 4) bit 1 selects the direction: 0 counts up, 1 counts down. Each transfer moves the counter by one, which is one byte on byte channels and one word on word channels.
- R5: The current address wraps modulo 2^16, and the page bits do not change when it wraps.
- R6: The count holds the transfer length minus one and decrements on each transfer. `xfer_tc` is 1 on the transfer whose count is 0, and the count then becomes 16'hFFFF.
- R7: Mode bit 0 set means that at terminal count the current address and count reload from their base registers instead of stepping.
- R8: Mode bit 0 clear means that terminal count blocks the channel, so later strobes give `xfer_valid`=0 until a write to select 6 with data bit 0 = 0 unblocks it. Data bit 0 = 1 blocks the channel.
- R9: A strobe on channel 4 never produces a transfer.
- R10: A write to select 7 (software request) changes no channel state and starts no transfer.
- R11: Selects 0 (base+current address) and 1 (base+current count) write the low byte and then the high byte, alternating on one shared pointer. A write to select 5 returns the pointer to the low byte. Selects 2 and 3 write the low and high page bytes.
- R12: The outputs for an accepted strobe appear after the next rising edge. In every other cycle `xfer_valid` and `xfer_tc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 3 | Channel addressed by the write |
| wr_sel | input | 3 | Register select: 0 address, 1 count, 2 page low, 3 page high, 4 mode, 5 pointer clear, 6 block, 7 software request |
| wr_data | input | 8 | Write data |
| xfer_stb | input | 1 | Hardware transfer strobe |
| xfer_ch | input | 3 | Channel of the strobe |
| xfer_valid | output | 1 | An accepted transfer is presented |
| xfer_addr | output | 32 | System byte address of the transfer |
| xfer_be | output | 2 | Active byte lanes |
| xfer_tc | output | 1 | Terminal count reached on this transfer |

## Verification
Every result of the block is due exactly one rising edge after its cause. A strobe's address, lanes and terminal count appear after the next edge. Register writes and the channel stepping take effect at that same edge and show up in the following strobe's result. The bench's model advances at each rising edge from the inputs sampled there. It compares on the falling edge that follows, so each comparison falls in the cycle where the output is due. Stimulus never strobes and writes in the same cycle.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

   typedef enum logic [2:0] {
      SEL_BASE_ADDR = 3'd0,
      SEL_BASE_CNT  = 3'd1,
      SEL_PAGE_LO   = 3'd2,
      SEL_PAGE_HI   = 3'd3,
      SEL_MODE      = 3'd4,
      SEL_CLR_PTR   = 3'd5,
      SEL_BLOCK     = 3'd6,
      SEL_SOFT_REQ  = 3'd7
   } reg_sel_e;

   localparam int MODE_AUTO_BIT = 0;
   localparam int MODE_DOWN_BIT = 1;

endpackage

// File: rtl/dma_ag_byteptr.sv
module dma_ag_byteptr
   import dma_ag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   output logic       hi_sel
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_sel <= 1'b0;
      end else if (wr_en) begin
         if (sel == SEL_CLR_PTR)
            hi_sel <= 1'b0;
         else if (sel == SEL_BASE_ADDR || sel == SEL_BASE_CNT)
            hi_sel <= ~hi_sel;
      end
   end
endmodule

// File: rtl/dma_ag_chan.sv
module dma_ag_chan
   import dma_ag_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              hi_sel,
   input  logic              stb,
   output logic [CNT_W-1:0]  cur_addr,
   output logic [PAGE_W-1:0] page_lo,
   output logic [PAGE_W-1:0] page_hi,
   output logic              blocked,
   output logic              cnt_zero
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] base_addr, base_cnt, cur_cnt;
   logic             auto_init, count_down;
   reg_sel_e         sel;

   assign sel      = reg_sel_e'(wr_sel);
   assign cnt_zero = (cur_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr  <= '0;
         base_cnt   <= '0;
         cur_addr   <= '0;
         cur_cnt    <= '0;
         page_lo    <= '0;
         page_hi    <= '0;
         auto_init  <= 1'b0;
         count_down <= 1'b0;
         blocked    <= 1'b0;
      end else if (wr_hit) begin
         case (sel)
            SEL_BASE_ADDR: begin
               if (hi_sel) begin
                  base_addr[CNT_W-1:DATA_W] <= wr_data;
                  cur_addr[CNT_W-1:DATA_W]  <= wr_data;
               end else begin
                  base_addr[DATA_W-1:0] <= wr_data;
                  cur_addr[DATA_W-1:0]  <= wr_data;
               end
            end
            SEL_BASE_CNT: begin
               if (hi_sel) begin
                  base_cnt[CNT_W-1:DATA_W] <= wr_data;
                  cur_cnt[CNT_W-1:DATA_W]  <= wr_data;
               end else begin
                  base_cnt[DATA_W-1:0] <= wr_data;
                  cur_cnt[DATA_W-1:0]  <= wr_data;
               end
            end
            SEL_PAGE_LO: page_lo <= PAGE_W'(wr_data);
            SEL_PAGE_HI: page_hi <= PAGE_W'(wr_data);
            SEL_MODE: begin
               auto_init  <= wr_data[MODE_AUTO_BIT];
               count_down <= wr_data[MODE_DOWN_BIT];
            end
            SEL_BLOCK: blocked <= wr_data[0];
            default: ;
         endcase
      end else if (stb) begin
         if (cnt_zero && auto_init) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
         end else begin
            cur_addr <= count_down ? cur_addr - ONE : cur_addr + ONE;
            cur_cnt  <= cur_cnt - ONE;
            if (cnt_zero)
               blocked <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_ag_fmt.sv
module dma_ag_fmt #(
   parameter int CNT_W  = 16,
   parameter int PAGE_W = 8,
   parameter int ADDR_W = 32,
   parameter bit WIDE   = 1'b0
) (
   input  logic [CNT_W-1:0]  cur_addr,
   input  logic [PAGE_W-1:0] page_lo,
   input  logic [PAGE_W-1:0] page_hi,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        be
);
   if (ADDR_W != CNT_W + 2 * PAGE_W) begin : g_bad_w
      $error("dma_ag_fmt: address width must equal counter plus two page bytes");
   end

   if (WIDE) begin : g_word
      logic unused_pg0;
      assign unused_pg0 = page_lo[0];
      assign addr = {page_hi, page_lo[PAGE_W-1:1], cur_addr, 1'b0};
      assign be   = 2'b11;
   end else begin : g_byte
      assign addr = {page_hi, page_lo, cur_addr};
      assign be   = cur_addr[0] ? 2'b10 : 2'b01;
   end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
   parameter int NUM_CH     = 8,
   parameter int CASCADE_CH = 4,
   parameter int FIRST_WIDE = 4,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 16,
   parameter int PAGE_W     = 8,
   parameter int ADDR_W     = 32,
   localparam int CH_W      = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              xfer_stb,
   input  logic [CH_W-1:0]   xfer_ch,
   output logic              xfer_valid,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [1:0]        xfer_be,
   output logic              xfer_tc
);
   if (NUM_CH != (1 << CH_W)) begin : g_bad_n
      $error("dma_addr_gen: channel count must be a power of two");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_c
      $error("dma_addr_gen: counter must be two write bytes wide");
   end
   if (CASCADE_CH >= NUM_CH || FIRST_WIDE > NUM_CH) begin : g_bad_idx
      $error("dma_addr_gen: cascade or width split index out of range");
   end

   logic              hi_sel, accept;
   logic [NUM_CH-1:0] masked_v, zero_v;
   logic [ADDR_W-1:0] addr_v [NUM_CH];
   logic [1:0]        be_v   [NUM_CH];

   dma_ag_byteptr u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .hi_sel (hi_sel)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      if (i == CASCADE_CH) begin : g_link
         assign masked_v[i] = 1'b1;
         assign zero_v[i]   = 1'b0;
         assign addr_v[i]   = '0;
         assign be_v[i]     = 2'b00;
      end else begin : g_live
         logic [CNT_W-1:0]  cur;
         logic [PAGE_W-1:0] plo, phi;
         logic              hit, go;

         assign hit = wr_en && (wr_ch == CH_W'(i));
         assign go  = accept && (xfer_ch == CH_W'(i));

         dma_ag_chan #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W),
            .PAGE_W (PAGE_W)
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit),
            .wr_sel   (wr_sel),
            .wr_data  (wr_data),
            .hi_sel   (hi_sel),
            .stb      (go),
            .cur_addr (cur),
            .page_lo  (plo),
            .page_hi  (phi),
            .blocked  (masked_v[i]),
            .cnt_zero (zero_v[i])
         );

         dma_ag_fmt #(
            .CNT_W  (CNT_W),
            .PAGE_W (PAGE_W),
            .ADDR_W (ADDR_W),
            .WIDE   (i >= FIRST_WIDE)
         ) u_fmt (
            .cur_addr (cur),
            .page_lo  (plo),
            .page_hi  (phi),
            .addr     (addr_v[i]),
            .be       (be_v[i])
         );
      end
   end

   assign accept = xfer_stb && !masked_v[xfer_ch];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_valid <= 1'b0;
         xfer_tc    <= 1'b0;
         xfer_addr  <= '0;
         xfer_be    <= 2'b00;
      end else begin
         xfer_valid <= accept;
         xfer_tc    <= accept && zero_v[xfer_ch];
         if (accept) begin
            xfer_addr <= addr_v[xfer_ch];
            xfer_be   <= be_v[xfer_ch];
         end
      end
   end
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
   parameter int NUM_CH     = 8,
   parameter int CASCADE_CH = 4,
   parameter int FIRST_WIDE = 4,
   parameter int ADDR_W     = 32,
   localparam int CH_W      = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_stb,
   input logic [CH_W-1:0]   xfer_ch,
   input logic              xfer_valid,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [1:0]        xfer_be,
   input logic              xfer_tc,
   input logic [NUM_CH-1:0] masked_v
);
   localparam logic [CH_W-1:0] LINK_IDX = CH_W'(CASCADE_CH);
   localparam logic [CH_W-1:0] WIDE_IDX = CH_W'(FIRST_WIDE);

   assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> $past(xfer_stb));

   assert_tc_with_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_tc |-> xfer_valid);

   assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && masked_v[xfer_ch]) |=> !xfer_valid);

   assert_no_cascade_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && xfer_ch == LINK_IDX) |=> !xfer_valid);

   assert_word_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && $past(xfer_ch) >= WIDE_IDX) |-> (!xfer_addr[0] && xfer_be == 2'b11));

   assert_byte_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && $past(xfer_ch) < WIDE_IDX) |->
         ($countones(xfer_be) == 1 && xfer_be[1] == xfer_addr[0]));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(
   .NUM_CH     (NUM_CH),
   .CASCADE_CH (CASCADE_CH),
   .FIRST_WIDE (FIRST_WIDE),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_stb   (xfer_stb),
   .xfer_ch    (xfer_ch),
   .xfer_valid (xfer_valid),
   .xfer_addr  (xfer_addr),
   .xfer_be    (xfer_be),
   .xfer_tc    (xfer_tc),
   .masked_v   (masked_v)
);

// File: tb/dma_addr_gen_test.sv
`timescale 1ns/1ps
module dma_addr_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_ch = '0;
   logic [2:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        xfer_stb = 1'b0;
   logic [2:0]  xfer_ch = '0;
   logic        xfer_valid;
   logic [31:0] xfer_addr;
   logic [1:0]  xfer_be;
   logic        xfer_tc;

   always #2.5 clk = ~clk;

   dma_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
      .wr_data(wr_data), .xfer_stb(xfer_stb), .xfer_ch(xfer_ch),
      .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_be(xfer_be), .xfer_tc(xfer_tc)
   );

   // behavioural model state, one entry per channel
   int base_a[8], base_c[8], cur_a[8], cur_c[8], plo[8], phi[8], ai[8], dn[8], mk[8];
   int ptr;
   logic        e_valid = 1'b0, e_tc = 1'b0;
   logic [31:0] e_addr = '0;
   logic [1:0]  e_be = '0;
   bit          comparing = 1'b0;
   string       tag = "R1";
   int          n_cmp = 0, n_bad = 0;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin
            base_a[i] = 0; base_c[i] = 0; cur_a[i] = 0; cur_c[i] = 0;
            plo[i] = 0; phi[i] = 0; ai[i] = 0; dn[i] = 0; mk[i] = 0;
         end
         ptr = 0; e_valid = 0; e_tc = 0;
      end else begin
         e_valid = 0; e_tc = 0;
         if (wr_en) begin
            int c, d;
            c = int'(wr_ch); d = int'(wr_data);
            case (int'(wr_sel))
               0: begin
                  if (ptr != 0) begin base_a[c] = (base_a[c] & 'hFF) | (d << 8); cur_a[c] = (cur_a[c] & 'hFF) | (d << 8); end
                  else begin base_a[c] = (base_a[c] & 'hFF00) | d; cur_a[c] = (cur_a[c] & 'hFF00) | d; end
                  ptr = 1 - ptr;
               end
               1: begin
                  if (ptr != 0) begin base_c[c] = (base_c[c] & 'hFF) | (d << 8); cur_c[c] = (cur_c[c] & 'hFF) | (d << 8); end
                  else begin base_c[c] = (base_c[c] & 'hFF00) | d; cur_c[c] = (cur_c[c] & 'hFF00) | d; end
                  ptr = 1 - ptr;
               end
               2: plo[c] = d;
               3: phi[c] = d;
               4: begin ai[c] = d & 1; dn[c] = (d >> 1) & 1; end
               5: ptr = 0;
               6: mk[c] = d & 1;
               default: ; // software request: no effect
            endcase
         end else if (xfer_stb) begin
            int c;
            c = int'(xfer_ch);
            if (c != 4 && mk[c] == 0) begin
               e_valid = 1;
               if (c >= 4) begin
                  e_addr = 32'((phi[c] * 16777216) + ((plo[c] / 2) * 131072) + cur_a[c] * 2);
                  e_be = 2'b11;
               end else begin
                  e_addr = 32'((phi[c] * 16777216) + plo[c] * 65536 + cur_a[c]);
                  e_be = (cur_a[c] % 2 == 1) ? 2'b10 : 2'b01;
               end
               e_tc = (cur_c[c] == 0);
               if (e_tc && ai[c] != 0) begin
                  cur_a[c] = base_a[c]; cur_c[c] = base_c[c];
               end else begin
                  cur_a[c] = (dn[c] != 0) ? (cur_a[c] + 65535) % 65536 : (cur_a[c] + 1) % 65536;
                  cur_c[c] = (cur_c[c] + 65535) % 65536;
                  if (e_tc) mk[c] = 1;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (comparing) begin
         chk("valid", 32'(xfer_valid), 32'(e_valid));
         chk("tc", 32'(xfer_tc), 32'(e_tc));
         if (e_valid) begin
            chk("addr", xfer_addr, e_addr);
            chk("be", 32'(xfer_be), 32'(e_be));
         end
      end
   end

   task automatic wr(int ch, int sel, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_ch = 3'(ch); wr_sel = 3'(sel); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic stb(int ch, int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         xfer_stb = 1'b1; xfer_ch = 3'(ch);
         @(negedge clk);
         xfer_stb = 1'b0;
      end
   endtask

   task automatic prog(int ch, int a, int cnt, int pl, int ph, int mode);
      wr(ch, 5, 0);
      wr(ch, 0, a & 'hFF);   wr(ch, 0, a >> 8);
      wr(ch, 1, cnt & 'hFF); wr(ch, 1, cnt >> 8);
      wr(ch, 2, pl); wr(ch, 3, ph); wr(ch, 4, mode);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      tag = "watchdog";
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      comparing = 1'b1;
      tag = "R1";   // reset outputs idle, channel 1 accepted unprogrammed-free
      repeat (3) @(negedge clk);
      chk("reset valid", 32'(xfer_valid), 32'd0);
      chk("reset tc", 32'(xfer_tc), 32'd0);
      tag = "R2";   // byte channel address and lanes
      prog(1, 'h1234, 2, 'h56, 'h78, 0);
      stb(1, 2);
      tag = "R6";   // third transfer hits terminal count
      stb(1, 1);
      tag = "R8";   // blocked after terminal count, then unblocked
      stb(1, 2);
      wr(1, 6, 0);
      stb(1, 2);
      wr(1, 6, 1);
      stb(1, 1);
      tag = "R7";   // auto reload, counting down
      prog(2, 'h0001, 1, 'hA0, 'h0F, 3);
      stb(2, 5);
      tag = "R5";   // byte counter wrap keeps page
      prog(3, 'hFFFE, 'hFFFF, 'h22, 'h33, 0);
      stb(3, 3);
      tag = "R3";   // word channel, page_lo bit 0 dropped, wraps in page
      prog(5, 'hFFFE, 3, 'h13, 'h9A, 0);
      stb(5, 4);
      tag = "R4";   // word channel counting down
      prog(6, 'h0002, 'h10, 'h44, 'h01, 2);
      stb(6, 4);
      tag = "R9";   // cascade channel never transfers
      prog(4, 'h0100, 5, 'h01, 'h01, 0);
      stb(4, 2);
      tag = "R10";  // software request write is ignored
      wr(5, 7, 'hFF);
      wr(0, 7, 'h01);
      stb(5, 1);
      stb(0, 1);
      tag = "R11";  // shared byte pointer and its clear
      wr(7, 5, 0);
      wr(7, 0, 'hAA);
      wr(3, 1, 'h00);
      wr(7, 5, 0);
      wr(7, 0, 'h11); wr(7, 0, 'h22);
      wr(7, 1, 'h01); wr(7, 1, 'h00);
      wr(7, 2, 'h05); wr(7, 3, 'hC0);
      stb(7, 3);
      tag = "R12";  // back-to-back strobes, one-cycle result each
      @(negedge clk); xfer_stb = 1'b1; xfer_ch = 3'd0;
      @(negedge clk); xfer_ch = 3'd6;
      @(negedge clk); xfer_ch = 3'd4;
      @(negedge clk); xfer_stb = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule